// File: doc/BRIEF.md
# Reset Source Capture Register

This block merges reset requests from several hardware sources into one system reset output. It records, in an 8-bit cause register, which source started the most recent reset. The sources are a power-on reset, an external reset pin, a watchdog overflow, a missing-clock timeout, a memory error, a USB reset event and a supply-monitor trip. Three of these sources are gated by enable bits that software sets. Software can also force a reset itself.

Software uses one register address, and bits on the read side and the write side have different meanings. A read returns the sticky cause flags. A write of the same bit positions loads the source enables or forces a software reset. For this reason software must never use read-modify-write on the register, because the value it reads back holds flags and not enables.

The control is a two-state machine. The states are `ST_HOLD` (reset asserted, counting) and `ST_RUN` (reset released). It has these transitions:

| Transition | From | To | Condition |
|---|---|---|---|
| power-on | any | `ST_HOLD` | power-on input low, asynchronous |
| trigger | `ST_RUN` | `ST_HOLD` | an accepted request is present |
| retrigger | `ST_HOLD` | `ST_HOLD` | an accepted request is present; the hold count restarts at 0 |
| release | `ST_HOLD` | `ST_RUN` | no request, and the hold count reaches its last value |

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst_o` is 1, the register reads 0x02 and every enable is cleared. After power-on, enable-gated sources are ignored until software enables them.
- R2: Bit 5 always reads 0. A write to bits 6, 5, 3 or 0 changes no flag and causes no reset.
- R3: The USB source is enabled by the value written to bit 7. An enabled USB event causes a reset, and afterwards the register reads 0x80. A disabled USB event is ignored.
- R4: Writing 1 to bit 4 while reset is released forces a reset, and afterwards the register reads 0x10.
- R5: The missing-clock timeout is enabled by the value written to bit 2. An enabled timeout causes a reset and reads 0x04. A disabled timeout is ignored.
- R6: The supply monitor is enabled by the value written to bit 1. An enabled trip causes a reset and reads 0x02. A disabled trip is ignored.
- R7: A watchdog overflow always causes a reset and reads 0x08. A memory error always causes a reset and reads 0x40.
- R8: A low level on `pin_rst_n` passes through a two-flop synchronizer. `sys_rst_o` rises in the third cycle after the pin is driven low, and the register then reads 0x01.
- R9: When several accepted requests arrive in the same cycle, only the flag with the highest bit number is set (bit 7 over 6 over 4 over 3 over 2 over 1 over 0).
- R10: `sys_rst_o` stays high for exactly 16 cycles after the last cycle with an accepted request. A new request during the hold restarts the count.
- R11: Enables survive every reset except power-on. Writing enables leaves the flags that read back unchanged.
- R12: Every reset other than power-on clears all old flags, so exactly one flag reads as 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| mcd_timeout_i | input | 1 | Missing-clock timeout pulse |
| mem_err_i | input | 1 | Memory error pulse |
| usb_evt_i | input | 1 | USB reset event pulse |
| vmon_trip_i | input | 1 | Supply-monitor trip pulse |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Cause flags read value |
| sys_rst_o | output | 1 | System reset output, active high |

## Verification
Assertions check the following on every cycle: exactly one flag is set, an accepted request raises the reset output in the next cycle, the reset output never falls straight after a request, enables change only on a write while reset is released, and the hold counter releases at its last value. The directed scenarios are the only place that shows values. These cover the flag code each source produces, the priority choice among sources firing together, the exact 16-cycle hold, the synchronizer latency, sources that are ignored while disabled, and enables that survive a non-power-on reset.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    localparam int REG_W     = 8;

    // Bit positions shared by the request vector, flags and write decode
    localparam int BIT_USB   = 7;
    localparam int BIT_MEM   = 6;
    localparam int BIT_SPARE = 5;
    localparam int BIT_SW    = 4;
    localparam int BIT_WDT   = 3;
    localparam int BIT_MCD   = 2;
    localparam int BIT_SUP   = 1;
    localparam int BIT_PIN   = 0;

    localparam logic [REG_W-1:0] POR_FLAGS = 8'h02;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } rcc_state_e;

endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rcc_prio.sv
module rcc_prio #(
    parameter int W = 8
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] grant
);

    // above[i] is set when any request at index i or higher is active
    logic [W:0] above;

    assign above[W] = 1'b0;

    for (genvar i = W - 1; i >= 0; i--) begin : g_chain
        assign above[i] = above[i+1] | req[i];
        assign grant[i] = req[i] & ~above[i+1];
    end

endmodule

// File: rtl/rcc_fsm.sv
module rcc_fsm
    import rcc_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic req_any,
    output logic sys_rst,
    output logic run
);

    localparam int CNT_W = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

    rcc_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    // next-state logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (req_any) begin
                    state_n = ST_HOLD;          // trigger
                    cnt_n   = '0;
                end
            end
            ST_HOLD: begin
                if (req_any) begin
                    cnt_n = '0;                 // retrigger
                end else if (cnt_q == CNT_LAST) begin
                    state_n = ST_RUN;           // release
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            default: begin
                state_n = ST_HOLD;
                cnt_n   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_HOLD;                 // power-on
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // outputs
    always_comb begin
        sys_rst = 1'b1;
        run     = 1'b0;
        unique case (state_q)
            ST_RUN:  begin sys_rst = 1'b0; run = 1'b1; end
            ST_HOLD: begin sys_rst = 1'b1; run = 1'b0; end
            default: begin sys_rst = 1'b1; run = 1'b0; end
        endcase
    end

    // R10: release happens exactly after the last hold count with no request
    assert_release_at_last_R10: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_HOLD && !req_any && cnt_q == CNT_LAST) |=> (state_q == ST_RUN));

    // R10: a request always restarts the hold count
    assert_retrigger_restart_R10: assert property (@(posedge clk) disable iff (!por_n)
        req_any |=> (state_q == ST_HOLD && cnt_q == '0));

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int HOLD_CYC    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             pin_rst_n,
    input  logic             wdt_ovf_i,
    input  logic             mcd_timeout_i,
    input  logic             mem_err_i,
    input  logic             usb_evt_i,
    input  logic             vmon_trip_i,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wr_data,
    output logic [REG_W-1:0] reg_rd_data,
    output logic             sys_rst_o
);

    logic             pin_sync_n;
    logic             run;
    logic             wr_ok;
    logic             en_usb_q, en_mcd_q, en_sup_q;
    logic [REG_W-1:0] req, win;
    logic             req_any;
    logic [REG_W-1:0] flags_q;
    logic             unused_wr_bits;

    rcc_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_pin_sync (
        .clk    (clk),
        .arst_n (por_n),
        .d      (pin_rst_n),
        .q      (pin_sync_n)
    );

    assign wr_ok = reg_wr_en & run;

    // request vector, one bit per flag position
    always_comb begin
        req            = '0;
        req[BIT_USB]   = usb_evt_i & en_usb_q;
        req[BIT_MEM]   = mem_err_i;
        req[BIT_SW]    = wr_ok & reg_wr_data[BIT_SW];
        req[BIT_WDT]   = wdt_ovf_i;
        req[BIT_MCD]   = mcd_timeout_i & en_mcd_q;
        req[BIT_SUP]   = vmon_trip_i & en_sup_q;
        req[BIT_PIN]   = ~pin_sync_n;
    end

    assign req_any = |req;

    rcc_prio #(.W(REG_W)) u_prio (
        .req   (req),
        .grant (win)
    );

    rcc_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk     (clk),
        .por_n   (por_n),
        .req_any (req_any),
        .sys_rst (sys_rst_o),
        .run     (run)
    );

    // enables: cleared only by power-on
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            en_usb_q <= 1'b0;
            en_mcd_q <= 1'b0;
            en_sup_q <= 1'b0;
        end else if (wr_ok) begin
            en_usb_q <= reg_wr_data[BIT_USB];
            en_mcd_q <= reg_wr_data[BIT_MCD];
            en_sup_q <= reg_wr_data[BIT_SUP];
        end
    end

    // cause flags: replaced by the winning source on every request
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flags_q <= POR_FLAGS;
        end else if (req_any) begin
            flags_q <= win;
        end
    end

    always_comb begin
        reg_rd_data            = flags_q;
        reg_rd_data[BIT_SPARE] = 1'b0;
    end

    assign unused_wr_bits = ^{reg_wr_data[BIT_MEM], reg_wr_data[BIT_SPARE],
                              reg_wr_data[BIT_WDT], reg_wr_data[BIT_PIN]};

    // R12: exactly one cause flag at all times
    assert_single_flag_R12: assert property (@(posedge clk) disable iff (!por_n)
        $countones(flags_q) == 1);

    // R10: an accepted request asserts the reset output next cycle
    assert_req_asserts_reset_R10: assert property (@(posedge clk) disable iff (!por_n)
        req_any |=> sys_rst_o);

    // R10: the reset output never drops right after a request
    assert_no_early_release_R10: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst_o) |-> !$past(req_any));

    // R11: enables move only on an accepted write
    assert_enable_stable_R11: assert property (@(posedge clk) disable iff (!por_n)
        !wr_ok |=> $stable({en_usb_q, en_mcd_q, en_sup_q}));

    // R11: flags hold when no request arrives
    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!por_n)
        !req_any |=> $stable(flags_q));

endmodule

// File: tb/rst_cause_ctrl_tb.sv
module rst_cause_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 16;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       pin_rst_n = 1'b1;
    logic       wdt_ovf_i = 1'b0;
    logic       mcd_timeout_i = 1'b0;
    logic       mem_err_i = 1'b0;
    logic       usb_evt_i = 1'b0;
    logic       vmon_trip_i = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic [7:0] reg_rd_data;
    logic       sys_rst_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_cause_ctrl u_dut (
        .clk           (clk),
        .por_n         (por_n),
        .pin_rst_n     (pin_rst_n),
        .wdt_ovf_i     (wdt_ovf_i),
        .mcd_timeout_i (mcd_timeout_i),
        .mem_err_i     (mem_err_i),
        .usb_evt_i     (usb_evt_i),
        .vmon_trip_i   (vmon_trip_i),
        .reg_wr_en     (reg_wr_en),
        .reg_wr_data   (reg_wr_data),
        .reg_rd_data   (reg_rd_data),
        .sys_rst_o     (sys_rst_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one-cycle pulse; returns at the negedge after the sampling posedge
    task automatic pulse(input logic usb, input logic mem, input logic wdt,
                         input logic mcd, input logic sup);
        @(negedge clk);
        usb_evt_i = usb; mem_err_i = mem; wdt_ovf_i = wdt;
        mcd_timeout_i = mcd; vmon_trip_i = sup;
        @(negedge clk);
        usb_evt_i = 0; mem_err_i = 0; wdt_ovf_i = 0;
        mcd_timeout_i = 0; vmon_trip_i = 0;
    endtask

    task automatic write_reg(input logic [7:0] val);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = val;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wr_data = 8'h00;
    endtask

    // counts negedges with reset high, starting at the current one
    task automatic wait_release(output int n);
        n = 0;
        while (sys_rst_o && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    // source that must reset, then show a single flag
    task automatic t_source(input string req, input logic usb, input logic mem,
                            input logic wdt, input logic mcd, input logic sup,
                            input logic [7:0] exp_flags);
        int n;
        pulse(usb, mem, wdt, mcd, sup);
        chk({req, " reset asserted"}, sys_rst_o, 1);
        wait_release(n);
        chk({req, " R10 hold length"}, n, HOLD);
        chk({req, " flags"}, reg_rd_data, exp_flags);
    endtask

    // source that must be ignored
    task automatic t_ignored(input string req, input logic usb, input logic mcd,
                             input logic sup, input logic [7:0] exp_flags);
        pulse(usb, 1'b0, 1'b0, mcd, sup);
        chk({req, " disabled source no reset"}, sys_rst_o, 0);
        chk({req, " disabled source no flag"}, reg_rd_data, exp_flags);
    endtask

    task automatic t_power_on;
        int n;
        por_n = 1'b0;
        #(CLK_PERIOD * 3);
        chk("R1 reset during power-on", sys_rst_o, 1);
        chk("R1 power-on flags", reg_rd_data, 8'h02);
        @(negedge clk);
        por_n = 1'b1;
        wait_release(n);
        chk("R1 released after power-on", sys_rst_o, 0);
        chk("R1 flags after power-on", reg_rd_data, 8'h02);
    endtask

    task automatic t_ignored_writes;
        write_reg(8'h69);
        chk("R2 ignored write no reset", sys_rst_o, 0);
        chk("R2 ignored write flags", reg_rd_data, 8'h02);
        chk("R2 bit5 reads zero", reg_rd_data[5], 0);
    endtask

    task automatic t_pin;
        int n;
        @(negedge clk);
        pin_rst_n = 1'b0;
        @(negedge clk);
        chk("R8 sync latency cycle1", sys_rst_o, 0);
        @(negedge clk);
        chk("R8 sync latency cycle2", sys_rst_o, 0);
        @(negedge clk);
        chk("R8 reset in third cycle", sys_rst_o, 1);
        pin_rst_n = 1'b1;
        wait_release(n);
        chk("R8 pin flag", reg_rd_data, 8'h01);
    endtask

    task automatic t_software;
        int n;
        write_reg(8'h96);           // force plus keep enables 7,2,1
        chk("R4 software reset asserted", sys_rst_o, 1);
        wait_release(n);
        chk("R4 R10 hold length", n, HOLD);
        chk("R4 software flag", reg_rd_data, 8'h10);
    endtask

    task automatic t_retrigger;
        int n;
        pulse(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        pulse(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        wait_release(n);
        chk("R10 retrigger restarts hold", n, HOLD);
        chk("R12 retrigger replaces flag", reg_rd_data, 8'h04);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_power_on();
        t_ignored_writes();
        t_ignored("R3", 1'b1, 1'b0, 1'b0, 8'h02);
        t_ignored("R5", 1'b0, 1'b1, 1'b0, 8'h02);
        t_ignored("R6", 1'b0, 1'b0, 1'b1, 8'h02);
        t_source("R7 watchdog", 0, 0, 1, 0, 0, 8'h08);
        t_source("R7 memory", 0, 1, 0, 0, 0, 8'h40);
        // enable USB, clock detector and supply monitor
        write_reg(8'h86);
        chk("R11 enable write no reset", sys_rst_o, 0);
        chk("R11 enable write keeps flags", reg_rd_data, 8'h40);
        t_source("R3 usb", 1, 0, 0, 0, 0, 8'h80);
        t_source("R5 clock", 0, 0, 0, 1, 0, 8'h04);
        t_source("R6 supply", 0, 0, 0, 0, 1, 8'h02);
        t_pin();
        t_software();
        t_source("R11 usb enable survives", 1, 0, 0, 0, 0, 8'h80);
        t_source("R9 mem over wdt and supply", 0, 1, 1, 0, 1, 8'h40);
        t_source("R9 usb over all", 1, 1, 1, 1, 1, 8'h80);
        t_source("R9 clock over supply", 0, 0, 0, 1, 1, 8'h04);
        t_retrigger();
        t_power_on();
        t_ignored("R1 enables cleared usb", 1'b1, 1'b0, 1'b0, 8'h02);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule